// File: doc/BRIEF.md
# DDR Write Strobe Sequencer

This block is the write data path that sits between a controller's local write interface and the DQ, DM and DQS pads of a DDR SDRAM. It accepts write commands on a ready/valid handshake and collects write data on a second handshake. Each data word is two beats wide, so one clock carries one beat pair, and each word comes with a per-byte mask. For every accepted command it schedules a burst of data clocks after a fixed write latency. It drives the data, the masks and the data strobe, together with separate output enables for each pin group.

Every output is produced as a per-clock word that a double-data-rate pad stage serialises. Half 0 is the first half of the clock and half 1 is the second. During a data clock the strobe word is high in half 0 and low in half 1. The pad stage launches the strobe a quarter clock later than the data, so each strobe edge lands in the middle of a beat. The strobe is driven low for one half-cycle before a write stream (preamble) and for one half-cycle after it (postamble). A command that arrives early enough is merged into the running stream, and the strobe then keeps toggling with no preamble or postamble between the bursts. When the data word is missing at the moment a data clock begins, the block writes a fully masked beat pair and raises a stall flag.

Top module: `ddr_wr_strobe_seq`

## Requirements
- R1: While reset is held, and after it is released, all of the following hold until a command is accepted: every output enable is low, `wr_stall` is low, `wd_ready` is low and `wr_cmd_ready` is high.
- R2: A command accepted at a clock edge (`wr_cmd_valid` and `wr_cmd_ready` both high) leaves one clock of write latency. Its first data clock is the second clock after that edge.
- R3: In a non-data clock that directly precedes a data clock, `dqs_oe[1]` is 1 and `dqs_out[1]` is 0. This is the preamble in the second half-cycle.
- R4: In a non-data clock that directly follows a data clock, `dqs_oe[0]` is 1 and `dqs_out[0]` is 0. This is the postamble. A half whose enable bit is 0 is high-impedance.
- R5: In every data clock, `dqs_oe` is 2'b11 and `dqs_out` is 2'b01. The strobe is high in half 0 and low in half 1.
- R6: In a data clock, `dq_out` carries the data word that was presented with `wd_valid` high in the previous clock. `dm_out` carries that word's mask in the same clock. Beat 0 is in the low half of each word, and a mask bit of 1 blocks its byte.
- R7: A command accepted so that its first data clock directly follows the last data clock of the previous burst produces no preamble or postamble between the two bursts. The strobe stays 2'b01 with full enable.
- R8: `wr_cmd_ready` is high exactly when no data clock is scheduled for any clock from two clocks ahead onwards.
- R9: If exactly one non-data clock lies between two bursts, that clock has `dqs_oe` 2'b11 and `dqs_out` 2'b00, because the postamble and preamble merge.
- R10: If `wd_valid` is low in the clock before a data clock, that data clock has `wr_stall` high, `dm_out` all ones and `dq_out` zero. The burst still takes its full length.
- R11: `dq_oe` and `dm_oe` are high only in data clocks. Outside data clocks, `dq_out`, `dm_out` and `dqs_out` are zero.
- R12: Each accepted command yields exactly BURST_LEN/2 data clocks. `wd_ready` is high in a clock exactly when the next clock is a data clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd_valid | input | 1 | Write command request |
| wr_cmd_ready | output | 1 | Command can be accepted this clock |
| wd_valid | input | 1 | Write data word present |
| wd_ready | output | 1 | Data word is taken at the coming edge |
| wd_data | input | 2*DQ_W | Beat pair, beat 0 in the low half |
| wd_mask | input | 2*DM_W | Byte masks for the beat pair, 1 blocks |
| wr_stall | output | 1 | Data clock ran without a data word |
| dq_out | output | 2*DQ_W | Data to the pad serialiser |
| dq_oe | output | 1 | Data pin output enable |
| dm_out | output | 2*DM_W | Mask to the pad serialiser |
| dm_oe | output | 1 | Mask pin output enable |
| dqs_out | output | 2 | Strobe level per half-cycle |
| dqs_oe | output | 2 | Strobe output enable per half-cycle |

## Verification
A burst counter that is loaded wrongly or counts down wrongly shows up within the same burst. The number of clocks with `dq_oe` high is wrong, and the postamble moves to the wrong clock. A fault in the merge decision shows up in the first back-to-back pair, either as a spurious low half in the strobe word or as a missing preamble. The bench therefore runs a sweep of command spacings from gapless to several idle clocks, with periodic data starvation. It checks every output in every clock against a schedule of data clocks that it keeps itself.

// File: rtl/ddrw_pkg.sv
package ddrw_pkg;

  // Kind of clock seen on the strobe pin
  typedef enum logic [2:0] {
    STB_IDLE,
    STB_PRE,
    STB_DATA,
    STB_POST,
    STB_TURN
  } stb_phase_e;

  function automatic int clocks_per_burst(input int burst_len);
    return burst_len / 2;
  endfunction

  function automatic int count_width(input int burst_len);
    return $clog2(burst_len / 2 + 1);
  endfunction

endpackage

// File: rtl/ddrw_sched.sv
module ddrw_sched
  import ddrw_pkg::*;
#(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  output logic cmd_ready,
  output logic acc_n,
  output logic dclk_q,
  output logic dclk_n
);

  localparam int CPB   = clocks_per_burst(BURST_LEN);
  localparam int CNT_W = count_width(BURST_LEN);

  logic             acc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  // A pending command blocks a new one unless bursts are one clock long
  always_comb begin
    if (acc_q) cmd_ready = (CPB == 1);
    else       cmd_ready = (32'(cnt_q) <= 32'd2);
  end

  always_comb begin
    acc_n  = cmd_valid && cmd_ready;
    cnt_en = acc_q || (cnt_q != '0);
    if (acc_q)             cnt_n = CNT_W'(CPB);
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
    else                   cnt_n = cnt_q;
    dclk_n = (cnt_n != '0);
    dclk_q = (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= 1'b0;
    else        acc_q <= acc_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

endmodule

// File: rtl/ddrw_strobe.sv
module ddrw_strobe
  import ddrw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_n,
  input  logic       dclk_q,
  input  logic       dclk_n,
  output logic [1:0] dqs_out,
  output logic [1:0] dqs_oe
);

  stb_phase_e phase_n;
  logic [1:0] oe_n;
  logic [1:0] lvl_n;
  logic       pre_n;
  logic       post_n;

  always_comb begin
    pre_n  = acc_n && !dclk_n;
    post_n = dclk_q && !dclk_n;
    if (dclk_n)                phase_n = STB_DATA;
    else if (pre_n && post_n)  phase_n = STB_TURN;
    else if (pre_n)            phase_n = STB_PRE;
    else if (post_n)           phase_n = STB_POST;
    else                       phase_n = STB_IDLE;
  end

  // Bit 0 is the first half-cycle, bit 1 the second
  always_comb begin
    unique case (phase_n)
      STB_DATA: begin oe_n = 2'b11; lvl_n = 2'b01; end
      STB_TURN: begin oe_n = 2'b11; lvl_n = 2'b00; end
      STB_PRE:  begin oe_n = 2'b10; lvl_n = 2'b00; end
      STB_POST: begin oe_n = 2'b01; lvl_n = 2'b00; end
      default:  begin oe_n = 2'b00; lvl_n = 2'b00; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dqs_oe  <= 2'b00;
      dqs_out <= 2'b00;
    end else begin
      dqs_oe  <= oe_n;
      dqs_out <= lvl_n;
    end
  end

endmodule

// File: rtl/ddrw_lane.sv
module ddrw_lane #(
  parameter int DQ_W = 16,
  parameter int DM_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dclk_n,
  input  logic            wd_valid,
  input  logic [DQ_W-1:0] beat_data,
  input  logic [DM_W-1:0] beat_mask,
  output logic [DQ_W-1:0] dq_q,
  output logic [DM_W-1:0] dm_q
);

  localparam int BYTE_W = DQ_W / DM_W;

  logic [DQ_W-1:0] dq_n;
  logic [DM_W-1:0] dm_n;

  for (genvar g = 0; g < DM_W; g++) begin : g_byte
    always_comb begin
      if (dclk_n && wd_valid) begin
        dq_n[g*BYTE_W +: BYTE_W] = beat_data[g*BYTE_W +: BYTE_W];
        dm_n[g]                  = beat_mask[g];
      end else begin
        dq_n[g*BYTE_W +: BYTE_W] = '0;
        dm_n[g]                  = dclk_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q <= '0;
      dm_q <= '0;
    end else begin
      dq_q <= dq_n;
      dm_q <= dm_n;
    end
  end

endmodule

// File: rtl/ddr_wr_strobe_seq.sv
module ddr_wr_strobe_seq #(
  parameter int DQ_W      = 16,
  parameter int DM_W      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd_valid,
  output logic              wr_cmd_ready,
  input  logic              wd_valid,
  output logic              wd_ready,
  input  logic [2*DQ_W-1:0] wd_data,
  input  logic [2*DM_W-1:0] wd_mask,
  output logic              wr_stall,
  output logic [2*DQ_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [2*DM_W-1:0] dm_out,
  output logic              dm_oe,
  output logic [1:0]        dqs_out,
  output logic [1:0]        dqs_oe
);

  localparam int BEATS = 2;

  logic acc_n;
  logic dclk_q;
  logic dclk_n;
  logic stall_n;

  ddrw_sched #(.BURST_LEN(BURST_LEN)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (wr_cmd_valid),
    .cmd_ready (wr_cmd_ready),
    .acc_n     (acc_n),
    .dclk_q    (dclk_q),
    .dclk_n    (dclk_n)
  );

  ddrw_strobe u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_n   (acc_n),
    .dclk_q  (dclk_q),
    .dclk_n  (dclk_n),
    .dqs_out (dqs_out),
    .dqs_oe  (dqs_oe)
  );

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    ddrw_lane #(.DQ_W(DQ_W), .DM_W(DM_W)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .dclk_n    (dclk_n),
      .wd_valid  (wd_valid),
      .beat_data (wd_data[b*DQ_W +: DQ_W]),
      .beat_mask (wd_mask[b*DM_W +: DM_W]),
      .dq_q      (dq_out[b*DQ_W +: DQ_W]),
      .dm_q      (dm_out[b*DM_W +: DM_W])
    );
  end

  always_comb begin
    wd_ready = dclk_n;
    stall_n  = dclk_n && !wd_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_oe    <= 1'b0;
      dm_oe    <= 1'b0;
      wr_stall <= 1'b0;
    end else begin
      dq_oe    <= dclk_n;
      dm_oe    <= dclk_n;
      wr_stall <= stall_n;
    end
  end

endmodule

// File: rtl/ddrw_seq_chk.sv
module ddrw_seq_chk #(
  parameter int DQ_W = 16,
  parameter int DM_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_cmd_valid,
  input logic              wr_cmd_ready,
  input logic              wd_ready,
  input logic              wr_stall,
  input logic [2*DQ_W-1:0] dq_out,
  input logic              dq_oe,
  input logic [2*DM_W-1:0] dm_out,
  input logic              dm_oe,
  input logic [1:0]        dqs_out,
  input logic [1:0]        dqs_oe
);

  a_r5_data_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_oe == 2'b11 && dqs_out == 2'b01));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0 && dm_out == '0 && dqs_out == 2'b00 && !dm_oe));

  a_r4_postamble: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |=> (dq_oe || (dqs_oe[0] && !dqs_out[0])));

  a_r3_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(dqs_oe[1] && !dqs_out[1]));

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_valid && wr_cmd_ready) |=> ##1 dq_oe);

  a_r12_ready_leads: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |=> dq_oe);

  a_r12_no_extra: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_ready |=> !dq_oe);

  a_r10_stall_masked: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |-> (dq_oe && dm_out == '1 && dq_out == '0));

endmodule

bind ddr_wr_strobe_seq ddrw_seq_chk #(.DQ_W(DQ_W), .DM_W(DM_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_cmd_valid (wr_cmd_valid),
  .wr_cmd_ready (wr_cmd_ready),
  .wd_ready     (wd_ready),
  .wr_stall     (wr_stall),
  .dq_out       (dq_out),
  .dq_oe        (dq_oe),
  .dm_out       (dm_out),
  .dm_oe        (dm_oe),
  .dqs_out      (dqs_out),
  .dqs_oe       (dqs_oe)
);

// File: tb/sim_ddr_wr_strobe_seq.sv
`timescale 1ns/1ps
module sim_ddr_wr_strobe_seq;

  localparam int DQ_W = 16;
  localparam int DM_W = 2;
  localparam int BL   = 4;
  localparam int CPB  = BL / 2;
  localparam int NCYC = 600;

  logic              clk;
  logic              rst_n;
  logic              wr_cmd_valid;
  logic              wr_cmd_ready;
  logic              wd_valid;
  logic              wd_ready;
  logic [2*DQ_W-1:0] wd_data;
  logic [2*DM_W-1:0] wd_mask;
  logic              wr_stall;
  logic [2*DQ_W-1:0] dq_out;
  logic              dq_oe;
  logic [2*DM_W-1:0] dm_out;
  logic              dm_oe;
  logic [1:0]        dqs_out;
  logic [1:0]        dqs_oe;

  ddr_wr_strobe_seq #(.DQ_W(DQ_W), .DM_W(DM_W), .BURST_LEN(BL)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
    .wd_valid(wd_valid), .wd_ready(wd_ready),
    .wd_data(wd_data), .wd_mask(wd_mask), .wr_stall(wr_stall),
    .dq_out(dq_out), .dq_oe(dq_oe), .dm_out(dm_out), .dm_oe(dm_oe),
    .dqs_out(dqs_out), .dqs_oe(dqs_oe)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks;
  int fails;
  int cur;
  bit done;

  bit              sched [0:NCYC+15];
  bit              wdv   [0:NCYC+15];
  logic [2*DQ_W-1:0] wdd [0:NCYC+15];
  logic [2*DM_W-1:0] wdm [0:NCYC+15];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s clock=%0d actual=%0h expected=%0h", req, cur, act, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog clock=%0d actual=%0h expected=%0h", cur, 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int  want_at;
    int  ncmd;
    bit  ed;
    bit  pre;
    bit  post;
    bit  busy_ahead;
    logic [1:0]        e_oe;
    logic [1:0]        e_lv;
    logic [2*DQ_W-1:0] e_dq;
    logic [2*DM_W-1:0] e_dm;
    bit  e_st;

    checks = 0; fails = 0; cur = -1; done = 0;
    for (int i = 0; i < NCYC + 16; i++) begin
      sched[i] = 1'b0; wdv[i] = 1'b0; wdd[i] = '0; wdm[i] = '0;
    end
    rst_n = 1'b0;
    wr_cmd_valid = 1'b0; wd_valid = 1'b0; wd_data = '0; wd_mask = '0;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(dqs_oe == 2'b00 && !dq_oe && !dm_oe, "R1 oe in reset", {dqs_oe, dq_oe, dm_oe}, 0);
      chk(!wr_stall && !wd_ready, "R1 flags in reset", {wr_stall, wd_ready}, 0);
      chk(wr_cmd_ready, "R1 ready in reset", wr_cmd_ready, 1);
    end
    rst_n = 1'b1;

    want_at = 2;
    ncmd = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(posedge clk);
      @(negedge clk);
      cur = cyc;
      ed   = sched[cyc];
      pre  = !ed && sched[cyc+1];
      post = !ed && (cyc > 0) && sched[cyc > 0 ? cyc-1 : 0];
      e_oe = ed ? 2'b11 : {pre, post};
      e_lv = ed ? 2'b01 : 2'b00;
      e_st = ed && (cyc > 0) && !wdv[cyc-1];
      if (ed && cyc > 0 && wdv[cyc-1]) begin
        e_dq = wdd[cyc-1]; e_dm = wdm[cyc-1];
      end else begin
        e_dq = '0; e_dm = ed ? '1 : '0;
      end
      busy_ahead = 1'b0;
      for (int k = cyc + 2; k < cyc + 8; k++) busy_ahead |= sched[k];

      // R3/R4/R5/R7/R9: strobe word per clock
      chk(dqs_oe == e_oe, ed ? "R5 strobe enable" : (pre && post) ? "R9 merged turn enable" :
          pre ? "R3 preamble enable" : post ? "R4 postamble enable" : "R7 strobe enable",
          dqs_oe, e_oe);
      chk(dqs_out == e_lv, ed ? "R5 strobe level" : "R4 strobe low", dqs_out, e_lv);
      // R11/R12: data enables only in data clocks
      chk(dq_oe == ed && dm_oe == ed, "R11 data enables", {dq_oe, dm_oe}, {ed, ed});
      chk(wd_ready == sched[cyc+1], "R12 wd_ready", wd_ready, sched[cyc+1]);
      // R6/R10: data, masks, stall
      chk(dq_out == e_dq, e_st ? "R10 stall data" : "R6 data word", dq_out, e_dq);
      chk(dm_out == e_dm, e_st ? "R10 stall mask" : "R6 mask word", dm_out, e_dm);
      chk(wr_stall == e_st, "R10 stall flag", wr_stall, e_st);
      // R8: command ready
      chk(wr_cmd_ready == !busy_ahead, "R8 cmd ready", wr_cmd_ready, !busy_ahead);

      // Drive inputs for this clock
      wd_valid = ((cyc % 7) != 3);
      wd_data  = {16'(cyc * 3 + 1), 16'(cyc ^ 16'hA5C3)};
      wd_mask  = 4'(cyc);
      wdv[cyc] = wd_valid; wdd[cyc] = wd_data; wdm[cyc] = wd_mask;

      wr_cmd_valid = (cyc >= want_at) && (cyc < NCYC - 12);
      if (wr_cmd_valid && wr_cmd_ready) begin
        // R2: data clocks two clocks after acceptance, BL/2 of them
        for (int k = 0; k < CPB; k++) sched[cyc + 2 + k] = 1'b1;
        ncmd++;
        want_at = cyc + 1 + (ncmd % 6);
      end
    end
    wr_cmd_valid = 1'b0;
    chk(ncmd > 20, "R2 commands issued", ncmd, 21);
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule